// File: doc/BRIEF.md
# Blanking Window Offset Timer

This block opens a blanking window a programmable number of timebase clock cycles after a chosen reference event. The reference is either the counter-equals-zero strobe or the period-match strobe of an external timebase, and one select input picks which. Software writes the offset and the window length into shadow registers. Both values take effect only at the next reference event. At that event a 16-bit down-counter is loaded with the offset. When the counter expires, the window output goes high for the programmed number of cycles.

The counter stops at zero and stays there until the next reference event. Its current value is available on an output port. If the counter expires while a window is still open, the window length count starts again from the full length, so the open window is restarted. A debug-halt input is accepted and has no effect on the counter or the window. Producing the timebase strobes and masking trip events with the window are left to neighbouring logic.

Top module: `blank_offset_timer`

## Requirements
- R1: After synchronous reset, `offset_cnt` is 0, `blank_out` is 0, and both shadow registers and the active length are 0.
- R2: The reference event is `tb_zero` when `ref_sel` is 0 and `tb_prd` when `ref_sel` is 1. A pulse on the strobe that is not selected changes neither `offset_cnt` nor `blank_out`.
- R3: A shadow write (`off_wr`, `len_wr`) changes no output until the next reference event. At the clock edge that samples a reference event, `offset_cnt` is loaded with the offset shadow value and the active length is loaded with the length shadow value. A write in the same cycle as a reference event lands in the shadow only.
- R4: After a load, `offset_cnt` falls by exactly 1 per clock. It reaches 0 and then holds at 0 until the next reference event.
- R5: With offset N loaded at edge E0, `blank_out` rises at edge E0+N+1. With N = 0 it rises on the edge right after the load.
- R6: With active length L, a window stays high for exactly L clock cycles. With L = 0, no window opens.
- R7: If the counter expires while `blank_out` is high, the window is restarted and stays high for L more cycles counted from the new expiry.
- R8: `dbg_halt` has no effect on `offset_cnt` or `blank_out`.
- R9: A reference event while the counter is still running reloads it. The expiry that the earlier load would have produced does not happen.
- R10: The counter expires at most once per reference event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_sel | input | 1 | Reference select: 0 = zero strobe, 1 = period strobe |
| tb_zero | input | 1 | Timebase counter-equals-zero strobe |
| tb_prd | input | 1 | Timebase period-match strobe |
| dbg_halt | input | 1 | Debug halt request (ignored) |
| off_wr | input | 1 | Write strobe for the offset shadow |
| off_wdata | input | 16 | Offset value in clock cycles |
| len_wr | input | 1 | Write strobe for the window-length shadow |
| len_wdata | input | 16 | Window length in clock cycles |
| offset_cnt | output | 16 | Current value of the offset down-counter |
| blank_out | output | 1 | Blanking window, registered |

## Verification
A reference strobe driven before edge E0 shows up in `offset_cnt` as the loaded offset just after E0. After that the count is N-k just after edge E0+k, and `blank_out` is high exactly for k from N+1 to N+L. The bench samples one time unit after each rising edge, numbers every edge from the reference load, and compares against these closed-form values. For restart and reload, the edge of each second strobe is placed at a known k, and the expected rising and falling edges are derived from the same formulas.

// File: rtl/bwo_pkg.sv
package bwo_pkg;
  typedef enum logic {
    REF_ZERO   = 1'b0,
    REF_PERIOD = 1'b1
  } ref_sel_e;

  localparam int DEF_CNT_W = 16;
endpackage

// File: rtl/bwo_shadow_regs.sv
// Shadow/active pair for the window length, plus the offset shadow.
// The offset's active copy is the down-counter itself (see bwo_offset_counter).
module bwo_shadow_regs #(
  parameter int CNT_W = bwo_pkg::DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_hit,
  input  logic             off_wr,
  input  logic [CNT_W-1:0] off_wdata,
  input  logic             len_wr,
  input  logic [CNT_W-1:0] len_wdata,
  output logic [CNT_W-1:0] sh_off,
  output logic [CNT_W-1:0] act_len
);
  logic [CNT_W-1:0] sh_len;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_off  <= '0;
      sh_len  <= '0;
      act_len <= '0;
    end else begin
      if (off_wr) sh_off <= off_wdata;
      if (len_wr) sh_len <= len_wdata;
      if (ref_hit) act_len <= sh_len;
    end
  end
endmodule

// File: rtl/bwo_offset_counter.sv
// Offset down-counter: loads at the reference, counts to zero, then holds.
// 'armed' makes sure each load produces at most one expiry pulse.
module bwo_offset_counter #(
  parameter int CNT_W = bwo_pkg::DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_hit,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic armed;

  assign expire = armed && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else if (ref_hit) begin
      cnt   <= load_val;
      armed <= 1'b1;
    end else if (armed) begin
      if (cnt == '0) armed <= 1'b0;
      else           cnt   <= cnt - ONE;
    end
  end
endmodule

// File: rtl/bwo_window_gen.sv
// Window generator: each expiry (re)starts the length count from the full value.
module bwo_window_gen #(
  parameter int CNT_W = bwo_pkg::DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             expire,
  input  logic [CNT_W-1:0] len,
  output logic             blank,
  output logic [CNT_W-1:0] win_cnt
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      blank   <= 1'b0;
      win_cnt <= '0;
    end else if (expire) begin
      blank   <= (len != '0);
      win_cnt <= len;
    end else if (blank) begin
      if (win_cnt == ONE) blank <= 1'b0;
      win_cnt <= win_cnt - ONE;
    end
  end
endmodule

// File: rtl/blank_offset_timer.sv
module blank_offset_timer
  import bwo_pkg::*;
#(
  parameter int CNT_W = DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_sel,
  input  logic             tb_zero,
  input  logic             tb_prd,
  input  logic             dbg_halt,
  input  logic             off_wr,
  input  logic [CNT_W-1:0] off_wdata,
  input  logic             len_wr,
  input  logic [CNT_W-1:0] len_wdata,
  output logic [CNT_W-1:0] offset_cnt,
  output logic             blank_out
);
  logic             ref_hit;
  logic [CNT_W-1:0] sh_off;
  logic [CNT_W-1:0] act_len;
  logic             expire;
  logic [CNT_W-1:0] win_cnt;
  logic             unused_halt;

  // The offset count runs on regardless of a debug halt.
  assign unused_halt = dbg_halt;

  assign ref_hit = (ref_sel_e'(ref_sel) == REF_PERIOD) ? tb_prd : tb_zero;

  bwo_shadow_regs #(.CNT_W(CNT_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .ref_hit   (ref_hit),
    .off_wr    (off_wr),
    .off_wdata (off_wdata),
    .len_wr    (len_wr),
    .len_wdata (len_wdata),
    .sh_off    (sh_off),
    .act_len   (act_len)
  );

  bwo_offset_counter #(.CNT_W(CNT_W)) u_offset (
    .clk      (clk),
    .rst      (rst),
    .ref_hit  (ref_hit),
    .load_val (sh_off),
    .cnt      (offset_cnt),
    .expire   (expire)
  );

  bwo_window_gen #(.CNT_W(CNT_W)) u_window (
    .clk     (clk),
    .rst     (rst),
    .expire  (expire),
    .len     (act_len),
    .blank   (blank_out),
    .win_cnt (win_cnt)
  );
endmodule

// File: rtl/bwo_checker.sv
module bwo_checker #(
  parameter int CNT_W = bwo_pkg::DEF_CNT_W
) (
  input logic             clk,
  input logic             rst,
  input logic             ref_sel,
  input logic             tb_zero,
  input logic             tb_prd,
  input logic [CNT_W-1:0] offset_cnt,
  input logic             blank_out,
  input logic [CNT_W-1:0] sh_off,
  input logic [CNT_W-1:0] win_cnt
);
  logic hit_seen;
  assign hit_seen = ref_sel ? tb_prd : tb_zero;

  // R3: a reference loads the shadow offset into the counter
  p_load_r3: assert property (@(posedge clk) disable iff (rst)
    hit_seen |=> offset_cnt == $past(sh_off));

  // R4: decrement by one per clock
  p_count_down_r4: assert property (@(posedge clk) disable iff (rst)
    (!hit_seen && offset_cnt != '0) |=> offset_cnt == $past(offset_cnt) - CNT_W'(1));

  // R4: hold at zero without a reference
  p_hold_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (!hit_seen && offset_cnt == '0) |=> offset_cnt == '0);

  // R5: the window only opens after the counter has reached zero
  p_rise_after_zero_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(blank_out) |-> $past(offset_cnt) == '0);

  // R6: an open window carries a nonzero remaining length
  p_open_len_r6: assert property (@(posedge clk) disable iff (rst)
    blank_out |-> win_cnt != '0);

  // R6: the window cannot close early while length remains
  p_no_early_close_r6: assert property (@(posedge clk) disable iff (rst)
    (blank_out && win_cnt > CNT_W'(1)) |=> (blank_out || win_cnt == '0));
endmodule

bind blank_offset_timer bwo_checker #(.CNT_W(CNT_W)) u_bwo_checker (
  .clk        (clk),
  .rst        (rst),
  .ref_sel    (ref_sel),
  .tb_zero    (tb_zero),
  .tb_prd     (tb_prd),
  .offset_cnt (offset_cnt),
  .blank_out  (blank_out),
  .sh_off     (sh_off),
  .win_cnt    (win_cnt)
);

// File: tb/test_blank_offset_timer.sv
`timescale 1ns/1ps
module test_blank_offset_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ref_sel = 1'b0;
  logic        tb_zero = 1'b0;
  logic        tb_prd = 1'b0;
  logic        dbg_halt = 1'b0;
  logic        off_wr = 1'b0;
  logic [15:0] off_wdata = '0;
  logic        len_wr = 1'b0;
  logic [15:0] len_wdata = '0;
  logic [15:0] offset_cnt;
  logic        blank_out;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  blank_offset_timer #(.CNT_W(16)) i_blank_offset_timer (
    .clk(clk), .rst(rst), .ref_sel(ref_sel), .tb_zero(tb_zero), .tb_prd(tb_prd),
    .dbg_halt(dbg_halt), .off_wr(off_wr), .off_wdata(off_wdata),
    .len_wr(len_wr), .len_wdata(len_wdata),
    .offset_cnt(offset_cnt), .blank_out(blank_out)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic write_shadows(input int n, input int l);
    off_wr = 1'b1; off_wdata = 16'(n);
    len_wr = 1'b1; len_wdata = 16'(l);
    step();
    off_wr = 1'b0; len_wr = 1'b0;
  endtask

  task automatic pulse_ref(input logic sel);
    if (sel) tb_prd = 1'b1; else tb_zero = 1'b1;
    step();
    tb_prd = 1'b0; tb_zero = 1'b0;
  endtask

  // One sweep point: offset n, length l, reference select sel.
  task automatic run_case(input logic sel, input int n, input int l);
    ref_sel = sel;
    write_shadows(n, l);
    // R2: the strobe that is not selected must not load or open anything
    pulse_ref(~sel);
    chk("R2 cnt after unselected strobe", offset_cnt, 0);
    chk("R2 blank after unselected strobe", blank_out, 0);
    pulse_ref(sel);
    chk("R3 cnt loaded at reference", offset_cnt, n);
    for (int k = 1; k <= n + l + 3; k++) begin
      // R3: junk shadow writes after the load have no visible effect
      off_wr = (k == 1); off_wdata = 16'hFFFF;
      len_wr = (k == 1); len_wdata = 16'h0100;
      // R8: debug halt toggles freely during the run
      dbg_halt = k[0];
      step();
      off_wr = 1'b0; len_wr = 1'b0;
      chk("R4/R8 offset count", offset_cnt, (k >= n) ? 0 : n - k);
      chk("R5/R6/R10 blank", blank_out, (k >= n + 1 && k <= n + l) ? 1 : 0);
    end
    dbg_halt = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst = 1'b0;
    // R1: reset state; a reference with reset shadows opens no window
    chk("R1 cnt after reset", offset_cnt, 0);
    chk("R1 blank after reset", blank_out, 0);
    pulse_ref(1'b0);
    chk("R1 reset shadow offset", offset_cnt, 0);
    for (int k = 1; k <= 4; k++) begin
      step();
      chk("R1 reset shadow length", blank_out, 0);
    end

    // Sweep: R2..R6, R8, R10
    for (int s = 0; s < 2; s++)
      for (int n = 0; n < 8; n++)
        for (int l = 0; l < 6; l++)
          run_case(s[0], n, l);

    // R7: expiry during an open window restarts it (N=2, L=10, refs at E0 and E5)
    ref_sel = 1'b0;
    write_shadows(2, 10);
    pulse_ref(1'b0);
    for (int k = 1; k <= 20; k++) begin
      tb_zero = (k == 5);
      step();
      tb_zero = 1'b0;
      chk("R7 restarted window", blank_out, (k >= 3 && k <= 17) ? 1 : 0);
    end

    // R9: reload mid-count (N=10 at E0, N=3 at E4, L=2): fires at E8 only
    ref_sel = 1'b1;
    write_shadows(10, 2);
    pulse_ref(1'b1);
    for (int k = 1; k <= 14; k++) begin
      off_wr = (k == 1); off_wdata = 16'd3;
      tb_prd = (k == 4);
      step();
      off_wr = 1'b0; tb_prd = 1'b0;
      if (k == 4) chk("R9 reload value", offset_cnt, 3);
      chk("R9 single expiry", blank_out, (k == 8 || k == 9) ? 1 : 0);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule